// File: doc/BRIEF.md
# Postfix Stack Calculator Core

This core evaluates a short arithmetic program written in postfix order. The program is stored in a 16-word, 9-bit storage array. A program counter walks one read port of the array. The other port serves as the operand stack: it is written on a push and read on a pop, both at the stack pointer. The two newest operands stay in registers: B holds the top and A holds the entry below it. Any deeper operands spill into the array, into the words the program has already consumed.

The next word is fetched while the current one executes, so each word takes one clock. A control state machine tracks how many operands are live. It detects malformed programs, and it stops on an end-of-program word. The surrounding logic loads the program through a load port while reset is held low. It then releases reset and waits for either the halt flag or the error flag.

Top module: `calc_core`

## Requirements
- R1: A word with bit 8 clear is an operand whose bits 7..0 are a two's-complement value. Executing it pushes that value as the new top of the operand stack.
- R2: A word with bit 8 set is a command. Command 9'h101 replaces the two newest operands with their sum. Command 9'h100 replaces them with the older operand minus the newer one.
- R3: Operands beyond the two held in registers are kept in the storage array and return in last-in, first-out order. Programs that nest up to eight operands deep evaluate correctly.
- R4: A sum or difference command issued while fewer than two operands are live sets `error`.
- R5: A command word whose low byte is not 8'h00, 8'h01 or 8'hFF sets `error`.
- R6: The end-of-program word 9'h1FF sets `halted` and presents the single remaining operand on `result` when exactly one operand is live. With any other operand count it sets `error`.
- R7: Sums and differences are truncated to 8 bits, so they wrap in two's complement, and overflow is not reported.
- R8: `halted` and `error` are never high together. Each stays high until reset. While `halted` is high, `result` does not change.
- R9: Fetch overlaps execution. The word at index k, counting from 0, executes on clock edge k+2 after reset is released. Once the core halts or faults, the program counter stops.
- R10: While `rst_n` is low, `halted` and `error` are low. The load port writes the word `ld_data` at address `ld_addr` on each rising clock edge where `ld_we` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low; also enables program loading |
| ld_we | input | 1 | Program word write strobe, honoured only while reset is low |
| ld_addr | input | 4 | Program word address |
| ld_data | input | 9 | Program word |
| result | output | 8 | Top operand; the final value once halted |
| halted | output | 1 | Program ended cleanly; sticky until reset |
| error | output | 1 | Malformed program detected; sticky until reset |

## Verification
The bound checker enforces on every cycle that the two end flags are exclusive and sticky, and that the result is frozen after a halt. It also checks that the program counter stops once execution ends, that the stack pointer rises by one after each spill, and that a refill is never requested from an empty stack. Arithmetic values, operand ordering, wrap-around, the error rules for each kind of malformed word, and the exact number of cycles until the end are visible only through the bench's programs. The bench runs a sweep of operand pairs through both commands and a set of deep nested programs. It also runs a stream of generated programs, each compared against an operand-stack model kept inside the bench.

// File: rtl/calc_pkg.sv
package calc_pkg;

   // operand-depth states of the control machine plus the two end states
   typedef enum logic [2:0] {
      ST_EMPTY = 3'd0,
      ST_ONE   = 3'd1,
      ST_TWO   = 3'd2,
      ST_DEEP  = 3'd3,
      ST_HALT  = 3'd4,
      ST_FAULT = 3'd5
   } calc_state_e;

   // register-transfer controls issued by the state machine each cycle
   typedef struct packed {
      logic fetch;      // latch next program word, advance pc
      logic push;       // spill A into the array at sp, sp+1
      logic shift;      // A <= B
      logic take_data;  // B <= operand from IR
      logic take_alu;   // B <= ALU result
      logic sub;        // ALU computes A - B instead of A + B
      logic pop;        // A <= array[sp-1], sp-1
   } calc_ctl_t;

endpackage

// File: rtl/calc_mem.sv
module calc_mem #(
   parameter int WORD_W = 9,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [WORD_W-1:0] wdata,
   input  logic [ADDR_W-1:0] stk_addr,
   output logic [WORD_W-1:0] stk_rdata,
   input  logic [ADDR_W-1:0] prg_addr,
   output logic [WORD_W-1:0] prg_rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [WORD_W-1:0] words [DEPTH];
   logic [DEPTH-1:0]  sel;

   // one-hot write decode, one enable per word
   for (genvar g = 0; g < DEPTH; g++) begin : g_dec
      assign sel[g] = we && (waddr == ADDR_W'(g));
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < DEPTH; i++) begin
         if (sel[i]) words[i] <= wdata;
      end
   end

   // both ports read without a clock
   assign stk_rdata = words[stk_addr];
   assign prg_rdata = words[prg_addr];

endmodule

// File: rtl/calc_alu.sv
module calc_alu #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   input  logic              sub,
   output logic [DATA_W-1:0] y
);

   // modular arithmetic: carries out of the top bit are discarded
   always_comb begin
      if (sub) y = opa - opb;
      else     y = opa + opb;
   end

endmodule

// File: rtl/calc_ctrl.sv
module calc_ctrl
   import calc_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ir_vld,
   input  logic [DATA_W:0] ir,
   input  logic            sp_one,
   output calc_ctl_t       ctl,
   output logic            halted,
   output logic            error
);

   localparam logic [DATA_W-1:0] OP_SUB = '0;
   localparam logic [DATA_W-1:0] OP_ADD = DATA_W'(1);
   localparam logic [DATA_W-1:0] OP_END = '1;

   calc_state_e state_q, state_d;
   logic        running, is_cmd;
   logic [DATA_W-1:0] code;

   assign running = (state_q != ST_HALT) && (state_q != ST_FAULT);
   assign is_cmd  = ir[DATA_W];
   assign code    = ir[DATA_W-1:0];

   always_comb begin
      ctl       = '0;
      state_d   = state_q;
      ctl.fetch = running;
      if (running && ir_vld) begin
         if (!is_cmd) begin
            ctl.take_data = 1'b1;
            ctl.shift     = (state_q != ST_EMPTY);
            ctl.push      = (state_q == ST_TWO) || (state_q == ST_DEEP);
            case (state_q)
               ST_EMPTY: state_d = ST_ONE;
               ST_ONE:   state_d = ST_TWO;
               default:  state_d = ST_DEEP;
            endcase
         end else if ((code == OP_SUB) || (code == OP_ADD)) begin
            if ((state_q == ST_TWO) || (state_q == ST_DEEP)) begin
               ctl.take_alu = 1'b1;
               ctl.sub      = (code == OP_SUB);
               if (state_q == ST_DEEP) begin
                  ctl.pop = 1'b1;
                  state_d = sp_one ? ST_TWO : ST_DEEP;
               end else begin
                  state_d = ST_ONE;
               end
            end else begin
               state_d = ST_FAULT;
            end
         end else if (code == OP_END) begin
            state_d = (state_q == ST_ONE) ? ST_HALT : ST_FAULT;
         end else begin
            state_d = ST_FAULT;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_EMPTY;
      else        state_q <= state_d;
   end

   assign halted = (state_q == ST_HALT);
   assign error  = (state_q == ST_FAULT);

endmodule

// File: rtl/calc_core.sv
module calc_core
   import calc_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_we,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic [DATA_W:0]   ld_data,
   output logic [DATA_W-1:0] result,
   output logic              halted,
   output logic              error
);

   localparam int WORD_W = DATA_W + 1;

   if (DATA_W < 2) begin : g_bad_data
      $error("calc_core: DATA_W must be at least 2");
   end
   if (ADDR_W < 2 || ADDR_W > 8) begin : g_bad_addr
      $error("calc_core: ADDR_W must lie in 2..8");
   end

   calc_ctl_t         ctl;
   logic [ADDR_W-1:0] pc_q, sp_q;
   logic [WORD_W-1:0] ir_q;
   logic              ir_vld_q;
   logic [DATA_W-1:0] a_q, b_q, alu_y;
   logic [WORD_W-1:0] stk_word, prg_word, wr_data;
   logic [ADDR_W-1:0] wr_addr;
   logic              wr_en;

   // the load port owns the write side while reset is held
   assign wr_en   = rst_n ? ctl.push : ld_we;
   assign wr_addr = rst_n ? sp_q     : ld_addr;
   assign wr_data = rst_n ? {1'b0, a_q} : ld_data;

   calc_mem #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_mem (
      .clk       (clk),
      .we        (wr_en),
      .waddr     (wr_addr),
      .wdata     (wr_data),
      .stk_addr  (sp_q - ADDR_W'(1)),
      .stk_rdata (stk_word),
      .prg_addr  (pc_q),
      .prg_rdata (prg_word)
   );

   calc_alu #(.DATA_W(DATA_W)) u_alu (
      .opa (a_q),
      .opb (b_q),
      .sub (ctl.sub),
      .y   (alu_y)
   );

   calc_ctrl #(.DATA_W(DATA_W)) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .ir_vld (ir_vld_q),
      .ir     (ir_q),
      .sp_one (sp_q == ADDR_W'(1)),
      .ctl    (ctl),
      .halted (halted),
      .error  (error)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q     <= '0;
         sp_q     <= '0;
         ir_q     <= '0;
         ir_vld_q <= 1'b0;
         a_q      <= '0;
         b_q      <= '0;
      end else begin
         if (ctl.fetch) begin
            ir_q     <= prg_word;
            ir_vld_q <= 1'b1;
            pc_q     <= pc_q + ADDR_W'(1);
         end
         if (ctl.push)     sp_q <= sp_q + ADDR_W'(1);
         else if (ctl.pop) sp_q <= sp_q - ADDR_W'(1);
         if (ctl.take_data)     b_q <= ir_q[DATA_W-1:0];
         else if (ctl.take_alu) b_q <= alu_y;
         if (ctl.shift)    a_q <= b_q;
         else if (ctl.pop) a_q <= stk_word[DATA_W-1:0];
      end
   end

   assign result = b_q;

endmodule

// File: rtl/calc_core_chk.sv
module calc_core_chk #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              halted,
   input logic              error,
   input logic [DATA_W-1:0] result,
   input logic              push,
   input logic              pop,
   input logic [ADDR_W-1:0] sp,
   input logic [ADDR_W-1:0] pc
);

   // R8
   end_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(halted && error));

   // R8
   halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted);

   // R8
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      error |=> error);

   // R8
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> $stable(result));

   // R9
   pc_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (halted || error) |=> $stable(pc));

   // R3
   pop_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> (sp != '0));

   // R3
   push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> (sp == $past(sp) + ADDR_W'(1)));

endmodule

bind calc_core calc_core_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .halted (halted),
   .error  (error),
   .result (result),
   .push   (ctl.push),
   .pop    (ctl.pop),
   .sp     (sp_q),
   .pc     (pc_q)
);

// File: tb/test_calc_core.sv
module test_calc_core;

   localparam int CLK_PERIOD = 10;
   localparam int NW = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ld_we = 1'b0;
   logic [3:0] ld_addr = '0;
   logic [8:0] ld_data = '0;
   logic [7:0] result;
   logic       halted, error;

   int checks = 0;
   int fails  = 0;

   logic [8:0] prog [NW];

   calc_core i_calc_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld_we   (ld_we),
      .ld_addr (ld_addr),
      .ld_data (ld_data),
      .result  (result),
      .halted  (halted),
      .error   (error)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // operand-stack model: kind 1 = halt, 2 = error; step = index of final word
   task automatic model(output int kind, output logic [7:0] res, output int step);
      logic [7:0] st [NW+1];
      int depth;
      depth = 0; kind = 2; res = '0; step = NW - 1;
      for (int i = 0; i < NW; i++) begin
         step = i;
         if (!prog[i][8]) begin
            st[depth] = prog[i][7:0];
            depth++;
         end else if (prog[i][7:0] == 8'h00 || prog[i][7:0] == 8'h01) begin
            if (depth < 2) begin kind = 2; return; end
            if (prog[i][7:0] == 8'h00) st[depth-2] = st[depth-2] - st[depth-1];
            else                       st[depth-2] = st[depth-2] + st[depth-1];
            depth--;
         end else if (prog[i][7:0] == 8'hFF) begin
            if (depth == 1) begin kind = 1; res = st[0]; end
            else kind = 2;
            return;
         end else begin
            kind = 2;
            return;
         end
      end
   endtask

   // load prog[] under reset, release, run, compare with the model
   task automatic run_prog(input string req);
      int kind, step, cyc;
      logic [7:0] res;
      logic [7:0] held;
      model(kind, res, step);
      @(negedge clk);
      rst_n = 1'b0;
      for (int i = 0; i < NW; i++) begin
         @(negedge clk);
         ld_we = 1'b1; ld_addr = 4'(i); ld_data = prog[i];
      end
      @(negedge clk);
      ld_we = 1'b0;
      // R10: flags low throughout reset
      check(!halted && !error, "R10 reset flags", {30'd0, halted, error}, 0);
      rst_n = 1'b1;
      cyc = 0;
      while (cyc < 40) begin
         @(posedge clk);
         cyc++;
         @(negedge clk);
         if (halted || error) break;
      end
      check(halted == (kind == 1) && error == (kind == 2),
            {req, " end kind"}, {30'd0, halted, error}, kind == 1 ? 2 : 1);
      if (kind == 1)
         check(result == res, {req, " result"}, int'(result), int'(res));
      // R9: word at index step ends the run on edge step+2
      check(cyc == step + 2, "R9 end cycle", cyc, step + 2);
      held = result;
      repeat (3) @(negedge clk);
      // R8: sticky flags and frozen result
      check(halted == (kind == 1) && error == (kind == 2) && !(halted && error),
            "R8 sticky", {30'd0, halted, error}, kind == 1 ? 2 : 1);
      if (kind == 1) check(result == held, "R8 result held", int'(result), int'(held));
   endtask

   task automatic fill_end();
      for (int i = 0; i < NW; i++) prog[i] = 9'h1FF;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      int lcg;
      int depth;
      // R1 R2 R7: operand pair sweep through both commands, wrap included
      for (int x = -127; x <= 127; x += 23) begin
         for (int y = -127; y <= 127; y += 23) begin
            for (int op = 0; op < 2; op++) begin
               fill_end();
               prog[0] = {1'b0, 8'(x)};
               prog[1] = {1'b0, 8'(y)};
               prog[2] = {8'h80, 1'(op)};
               run_prog(op == 0 ? "R2 sub pair R7" : "R2 add pair R1");
            end
         end
      end
      // R2 R3: the worked example, 3 5 8 6 - + + gives 10
      fill_end();
      prog[0] = 9'd3; prog[1] = 9'd5; prog[2] = 9'd8; prog[3] = 9'd6;
      prog[4] = 9'h100; prog[5] = 9'h101; prog[6] = 9'h101;
      run_prog("R3 example");
      check(result == 8'd10, "R2 example value", int'(result), 10);
      // R3: eight operands deep, alternating commands (16 words)
      fill_end();
      for (int i = 0; i < 8; i++) prog[i] = {1'b0, 8'(10 * i + 3)};
      for (int i = 0; i < 7; i++) prog[8 + i] = {8'h80, 1'(i % 2)};
      run_prog("R3 deep nest");
      // R4: too few operands
      fill_end(); prog[0] = 9'h101; run_prog("R4 cmd on empty");
      fill_end(); prog[0] = 9'd7; prog[1] = 9'h100; run_prog("R4 cmd on one");
      // R5: unknown command codes
      fill_end(); prog[0] = 9'd1; prog[1] = 9'd2; prog[2] = 9'h102; run_prog("R5 code 02");
      fill_end(); prog[0] = 9'd1; prog[1] = 9'd2; prog[2] = 9'h1FE; run_prog("R5 code FE");
      // R6: end word with zero or two operands live
      fill_end(); run_prog("R6 end empty");
      fill_end(); prog[0] = 9'd4; prog[1] = 9'd9; run_prog("R6 end two");
      fill_end(); prog[0] = 9'h0F0; run_prog("R6 end single");
      // R3 R4 R5 R6: generated programs against the model
      lcg = 12345;
      for (int n = 0; n < 300; n++) begin
         fill_end();
         depth = 0;
         for (int i = 0; i < NW - 1; i++) begin
            lcg = lcg * 1103515245 + 12345;
            if (((lcg >>> 16) & 31) == 0)       prog[i] = {1'b1, 8'(lcg >>> 8)};
            else if (depth >= 2 && ((lcg >>> 20) & 1) == 1) begin
               prog[i] = {8'h80, 1'(lcg >>> 21)}; depth--;
            end else if (depth < 1 || ((lcg >>> 22) & 3) != 0) begin
               prog[i] = {1'b0, 8'(lcg >>> 9)}; depth++;
            end else prog[i] = 9'h1FF;
         end
         run_prog("R3 generated");
      end
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule